// File: doc/BRIEF.md
# AXI4 Burst Memory Slave

This block is an AXI4 slave backed by a small on-chip register-array memory. It serves complete write and read transactions over the five independent channels (write address, write data, write response, read address, read data). It runs one write transaction and one read transaction at a time, and the two sides proceed in parallel. Beat addresses follow the FIXED, INCR or WRAP rules. Narrow beats touch only the byte lanes that fall inside their window, and the write strobes choose which of those lanes are stored.

Both address channels accept a request in one cycle whenever their side is idle. The slave holds one write-data beat that arrives before its address, or in the same cycle as it, and applies that beat once the address is known. Each write ends with a single response. Each read beat carries its own response code, and the final beat of a read carries the last-beat flag. A beat that falls outside the memory, or that belongs to an illegal burst description, takes the error code and leaves the memory unchanged. The burst still runs for its full length.

Top module: `burst_mem_slave`

## Requirements
- R1: After reset, and whenever a side is idle, `awReady` (write side) and `arReady` (read side) are high, so an address transfer completes in the cycle it is offered. Neither is high while its side has a transaction in progress.
- R2: The length field holds the beat count minus one. An INCR burst of 1 to 256 beats places beat 0 at the start address and beat i at the start address aligned down to the beat size plus i times the bytes per beat.
- R3: In a FIXED burst every beat uses the start address.
- R4: A WRAP burst of 2, 4, 8 or 16 beats (length field 1, 3, 7, 15) steps like INCR. On reaching the aligned boundary of beat count times bytes per beat, the address returns to that boundary's base.
- R5: The bytes per beat equal 2 to the power of the 3-bit size field. A beat may only write the lanes from (address mod bus bytes) aligned down to the beat size, up through the next size-many lanes.
- R6: `wStrb` has one bit per data byte, with bit b covering `wData[8b+7:8b]`. Only lanes whose strobe bit is set are written.
- R7: A first write-data beat that arrives before its address, or in the same cycle, is accepted into a one-beat holding stage and written at the correct address once the address has been accepted.
- R8: Exactly one write response is given per write transaction, and only after the beat with `wLast` has been accepted. `bId` equals the request's `awId`. `bValid`, `bResp` and `bId` stay constant until `bReady`.
- R9: Read beats appear only after the read address has been accepted. `rId` equals `arId`, and `rLast` is high on the final beat only. `rData`, `rResp` and `rLast` stay constant while `rValid` is high and `rReady` is low.
- R10: These conditions produce SLVERR (2'b10) instead of OKAY (2'b00): a beat address at or beyond the memory size; a size field above the bus width; burst code 2'b11; a FIXED or WRAP length field above 15; a WRAP length field other than 1, 3, 7 or 15. An erroring write beat changes no memory. A write response is SLVERR if any of its beats erred. Each read beat reports its own code. Every burst still runs for its full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| awId | input | ID_W | Write transaction tag |
| awAddr | input | ADDR_W | Write start byte address |
| awLen | input | 8 | Write beat count minus one |
| awSize | input | 3 | Write beat size code (bytes = 2^code) |
| awBurst | input | 2 | Write burst kind: 00 FIXED, 01 INCR, 10 WRAP |
| awValid | input | 1 | Write address offered |
| awReady | output | 1 | Write address accepted |
| wData | input | DATA_W | Write beat data |
| wStrb | input | DATA_W/8 | Write byte enables |
| wLast | input | 1 | Final write beat marker |
| wValid | input | 1 | Write beat offered |
| wReady | output | 1 | Write beat accepted |
| bId | output | ID_W | Response tag |
| bResp | output | 2 | Write response code |
| bValid | output | 1 | Write response offered |
| bReady | input | 1 | Write response taken |
| arId | input | ID_W | Read transaction tag |
| arAddr | input | ADDR_W | Read start byte address |
| arLen | input | 8 | Read beat count minus one |
| arSize | input | 3 | Read beat size code |
| arBurst | input | 2 | Read burst kind |
| arValid | input | 1 | Read address offered |
| arReady | output | 1 | Read address accepted |
| rId | output | ID_W | Read data tag |
| rData | output | DATA_W | Read beat data (whole word) |
| rResp | output | 2 | Per-beat read response code |
| rLast | output | 1 | Final read beat marker |
| rValid | output | 1 | Read beat offered |
| rReady | input | 1 | Read beat taken |

## Verification
The bench targets the wrap point of WRAP bursts, both when written and when read from a mid-window start. A design that wraps at the wrong boundary would write into the next window, and the read-back would not match. It sends a first data beat before its address and another in the same cycle as its address. A slave that dropped or stalled wrongly on the early beat would hang or store it at the wrong location. It runs a 256-beat byte-wide INCR burst, narrow half-word beats and alternating strobes, which expose lane-masking errors as corrupted neighbouring bytes. It also runs bursts that straddle the end of memory or carry illegal descriptions; a slave that wrote on error or cut the burst short would change memory, miss SLVERR, or put `rLast` on the wrong beat.

// File: rtl/bms_pkg.sv
package bms_pkg;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  localparam logic [1:0] KIND_FIXED = 2'b00;
  localparam logic [1:0] KIND_INCR  = 2'b01;
  localparam logic [1:0] KIND_WRAP  = 2'b10;

  typedef enum logic [1:0] {WR_IDLE, WR_DATA, WR_RESP} wr_state_e;
  typedef enum logic       {RD_IDLE, RD_DATA}          rd_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrStart;   // latch write descriptor
    logic wrBeat;    // apply one write beat
    logic wrUseBuf;  // the beat comes from the holding stage
    logic bufFill;   // capture an early beat into the holding stage
    logic rdStart;   // latch read descriptor and fetch beat 0
    logic rdBeat;    // advance to the next read beat
  } dp_ctrl_t;

  // Address of the beat following addr
  function automatic logic [31:0] nextBeatAddr(logic [31:0] addr, logic [2:0] size,
                                               logic [7:0] len, logic [1:0] kind);
    logic [31:0] step;
    logic [31:0] inc;
    logic [31:0] span;
    logic [31:0] base;
    step = 32'd1 << size;
    inc  = (addr & ~(step - 32'd1)) + step;
    span = step * (32'(len) + 32'd1);
    base = addr & ~(span - 32'd1);
    case (kind)
      KIND_FIXED: return addr;
      KIND_WRAP:  return ((inc - base) >= span) ? base : inc;
      default:    return inc;
    endcase
  endfunction

  // Illegal burst description
  function automatic logic descErr(logic [2:0] size, logic [7:0] len,
                                   logic [1:0] kind, logic [2:0] maxSize);
    logic wrapLenOk;
    wrapLenOk = (len == 8'd1) || (len == 8'd3) || (len == 8'd7) || (len == 8'd15);
    return (size > maxSize) || (kind == 2'b11) ||
           ((kind != KIND_INCR) && (len > 8'd15)) ||
           ((kind == KIND_WRAP) && !wrapLenOk);
  endfunction

endpackage

// File: rtl/bms_datapath.sv
module bms_datapath
  import bms_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int ID_W      = 4,
  parameter int MEM_WORDS = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dp_ctrl_t              ctrl,
  input  logic [ID_W-1:0]       awId,
  input  logic [ADDR_W-1:0]     awAddr,
  input  logic [7:0]            awLen,
  input  logic [2:0]            awSize,
  input  logic [1:0]            awBurst,
  input  logic [DATA_W-1:0]     wData,
  input  logic [DATA_W/8-1:0]   wStrb,
  input  logic                  wLast,
  input  logic [ID_W-1:0]       arId,
  input  logic [ADDR_W-1:0]     arAddr,
  input  logic [7:0]            arLen,
  input  logic [2:0]            arSize,
  input  logic [1:0]            arBurst,
  output logic                  bufValid,
  output logic                  beatLast,
  output logic [ID_W-1:0]       bId,
  output logic [1:0]            bResp,
  output logic [ID_W-1:0]       rId,
  output logic [DATA_W-1:0]     rData,
  output logic [1:0]            rResp,
  output logic                  rLast
);

  localparam int BYTES     = DATA_W / 8;
  localparam int LANE_W    = $clog2(BYTES);
  localparam int IDX_W     = $clog2(MEM_WORDS);
  localparam int MEM_BYTES = MEM_WORDS * BYTES;
  localparam logic [2:0] MAX_SIZE = 3'(LANE_W);

  function automatic logic [BYTES-1:0] laneMask(logic [31:0] addr, logic [2:0] size);
    logic [BYTES-1:0] m;
    int nb;
    int lo;
    nb = 1 << size;
    lo = int'(addr[LANE_W-1:0]) & ~(nb - 1);
    for (int b = 0; b < BYTES; b++) m[b] = (b >= lo) && (b < lo + nb);
    return m;
  endfunction

  logic [DATA_W-1:0] mem [MEM_WORDS];

  // write side state
  logic [31:0]       wrAddr;
  logic [2:0]        wrSize;
  logic [7:0]        wrLen;
  logic [1:0]        wrKind;
  logic              wrDescErr;
  logic              wrErrAcc;
  logic [ID_W-1:0]   wrIdQ;

  // holding stage for an early beat
  logic              bufValidQ;
  logic [DATA_W-1:0] bufData;
  logic [BYTES-1:0]  bufStrb;
  logic              bufLast;

  // current write beat
  logic [DATA_W-1:0] beatData;
  logic [BYTES-1:0]  beatStrb;
  logic              beatErr;
  logic [BYTES-1:0]  laneEn;
  logic [IDX_W-1:0]  wrIdx;

  assign beatData = ctrl.wrUseBuf ? bufData : wData;
  assign beatStrb = ctrl.wrUseBuf ? bufStrb : wStrb;
  assign beatLast = ctrl.wrUseBuf ? bufLast : wLast;
  assign beatErr  = wrDescErr || (wrAddr >= 32'(MEM_BYTES));
  assign laneEn   = beatStrb & laneMask(wrAddr, wrSize);
  assign wrIdx    = wrAddr[LANE_W +: IDX_W];

  assign bufValid = bufValidQ;
  assign bId      = wrIdQ;
  assign bResp    = wrErrAcc ? RESP_SLVERR : RESP_OKAY;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrAddr    <= '0;
      wrSize    <= '0;
      wrLen     <= '0;
      wrKind    <= '0;
      wrDescErr <= 1'b0;
      wrErrAcc  <= 1'b0;
      wrIdQ     <= '0;
    end else if (ctrl.wrStart) begin
      wrAddr    <= 32'(awAddr);
      wrSize    <= awSize;
      wrLen     <= awLen;
      wrKind    <= awBurst;
      wrDescErr <= descErr(awSize, awLen, awBurst, MAX_SIZE);
      wrErrAcc  <= 1'b0;
      wrIdQ     <= awId;
    end else if (ctrl.wrBeat) begin
      wrAddr    <= nextBeatAddr(wrAddr, wrSize, wrLen, wrKind);
      wrErrAcc  <= wrErrAcc | beatErr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufValidQ <= 1'b0;
      bufData   <= '0;
      bufStrb   <= '0;
      bufLast   <= 1'b0;
    end else if (ctrl.bufFill) begin
      bufValidQ <= 1'b1;
      bufData   <= wData;
      bufStrb   <= wStrb;
      bufLast   <= wLast;
    end else if (ctrl.wrBeat && ctrl.wrUseBuf) begin
      bufValidQ <= 1'b0;
    end
  end

  // storage, one byte-lane write enable per lane
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= '0;
    end else if (ctrl.wrBeat && !beatErr) begin
      for (int b = 0; b < BYTES; b++)
        if (laneEn[b]) mem[wrIdx][8*b +: 8] <= beatData[8*b +: 8];
    end
  end

  // read side state
  logic [31:0]       rdAddr;
  logic [2:0]        rdSize;
  logic [7:0]        rdLen;
  logic [1:0]        rdKind;
  logic              rdDescErr;
  logic [7:0]        rdCnt;
  logic [ID_W-1:0]   rdIdQ;
  logic [DATA_W-1:0] rdDataQ;
  logic              rdErrQ;

  logic [31:0]       fetchAddr;
  logic              fetchErr;
  logic [IDX_W-1:0]  fetchIdx;

  always_comb begin
    if (ctrl.rdStart) begin
      fetchAddr = 32'(arAddr);
      fetchErr  = descErr(arSize, arLen, arBurst, MAX_SIZE);
    end else begin
      fetchAddr = nextBeatAddr(rdAddr, rdSize, rdLen, rdKind);
      fetchErr  = rdDescErr;
    end
    fetchErr = fetchErr || (fetchAddr >= 32'(MEM_BYTES));
    fetchIdx = fetchAddr[LANE_W +: IDX_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdAddr    <= '0;
      rdSize    <= '0;
      rdLen     <= '0;
      rdKind    <= '0;
      rdDescErr <= 1'b0;
      rdCnt     <= '0;
      rdIdQ     <= '0;
      rdDataQ   <= '0;
      rdErrQ    <= 1'b0;
    end else if (ctrl.rdStart) begin
      rdAddr    <= fetchAddr;
      rdSize    <= arSize;
      rdLen     <= arLen;
      rdKind    <= arBurst;
      rdDescErr <= descErr(arSize, arLen, arBurst, MAX_SIZE);
      rdCnt     <= '0;
      rdIdQ     <= arId;
      rdDataQ   <= fetchErr ? '0 : mem[fetchIdx];
      rdErrQ    <= fetchErr;
    end else if (ctrl.rdBeat) begin
      rdAddr    <= fetchAddr;
      rdCnt     <= rdCnt + 8'd1;
      rdDataQ   <= fetchErr ? '0 : mem[fetchIdx];
      rdErrQ    <= fetchErr;
    end
  end

  assign rId   = rdIdQ;
  assign rData = rdDataQ;
  assign rResp = rdErrQ ? RESP_SLVERR : RESP_OKAY;
  assign rLast = (rdCnt == rdLen);

endmodule

// File: rtl/bms_control.sv
module bms_control
  import bms_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     awValid,
  input  logic     wValid,
  input  logic     bReady,
  input  logic     arValid,
  input  logic     rReady,
  input  logic     bufValid,
  input  logic     beatLast,
  input  logic     rLast,
  output logic     awReady,
  output logic     wReady,
  output logic     bValid,
  output logic     arReady,
  output logic     rValid,
  output dp_ctrl_t ctrl
);

  wr_state_e wrState, wrNext;
  rd_state_e rdState, rdNext;

  assign awReady = (wrState == WR_IDLE);
  assign wReady  = !bufValid;  // live beats only while the holding stage is empty
  assign bValid  = (wrState == WR_RESP);
  assign arReady = (rdState == RD_IDLE);
  assign rValid  = (rdState == RD_DATA);

  always_comb begin
    ctrl          = '0;
    ctrl.wrStart  = awValid && awReady;
    ctrl.bufFill  = wValid && wReady && (wrState != WR_DATA);
    ctrl.wrBeat   = (wrState == WR_DATA) && (bufValid || wValid);
    ctrl.wrUseBuf = bufValid;
    ctrl.rdStart  = arValid && arReady;
    ctrl.rdBeat   = rValid && rReady && !rLast;
  end

  always_comb begin
    wrNext = wrState;
    case (wrState)
      WR_IDLE: if (ctrl.wrStart) wrNext = WR_DATA;
      WR_DATA: if (ctrl.wrBeat && beatLast) wrNext = WR_RESP;
      WR_RESP: if (bReady) wrNext = WR_IDLE;
      default: wrNext = WR_IDLE;
    endcase
  end

  always_comb begin
    rdNext = rdState;
    case (rdState)
      RD_IDLE: if (ctrl.rdStart) rdNext = RD_DATA;
      RD_DATA: if (rReady && rLast) rdNext = RD_IDLE;
      default: rdNext = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrState <= WR_IDLE;
      rdState <= RD_IDLE;
    end else begin
      wrState <= wrNext;
      rdState <= rdNext;
    end
  end

endmodule

// File: rtl/burst_mem_slave.sv
module burst_mem_slave
  import bms_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int ID_W      = 4,
  parameter int MEM_WORDS = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ID_W-1:0]     awId,
  input  logic [ADDR_W-1:0]   awAddr,
  input  logic [7:0]          awLen,
  input  logic [2:0]          awSize,
  input  logic [1:0]          awBurst,
  input  logic                awValid,
  output logic                awReady,
  input  logic [DATA_W-1:0]   wData,
  input  logic [DATA_W/8-1:0] wStrb,
  input  logic                wLast,
  input  logic                wValid,
  output logic                wReady,
  output logic [ID_W-1:0]     bId,
  output logic [1:0]          bResp,
  output logic                bValid,
  input  logic                bReady,
  input  logic [ID_W-1:0]     arId,
  input  logic [ADDR_W-1:0]   arAddr,
  input  logic [7:0]          arLen,
  input  logic [2:0]          arSize,
  input  logic [1:0]          arBurst,
  input  logic                arValid,
  output logic                arReady,
  output logic [ID_W-1:0]     rId,
  output logic [DATA_W-1:0]   rData,
  output logic [1:0]          rResp,
  output logic                rLast,
  output logic                rValid,
  input  logic                rReady
);

  dp_ctrl_t ctrl;
  logic     bufValid;
  logic     beatLast;

  bms_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .awValid  (awValid),
    .wValid   (wValid),
    .bReady   (bReady),
    .arValid  (arValid),
    .rReady   (rReady),
    .bufValid (bufValid),
    .beatLast (beatLast),
    .rLast    (rLast),
    .awReady  (awReady),
    .wReady   (wReady),
    .bValid   (bValid),
    .arReady  (arReady),
    .rValid   (rValid),
    .ctrl     (ctrl)
  );

  bms_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .ID_W      (ID_W),
    .MEM_WORDS (MEM_WORDS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .awId     (awId),
    .awAddr   (awAddr),
    .awLen    (awLen),
    .awSize   (awSize),
    .awBurst  (awBurst),
    .wData    (wData),
    .wStrb    (wStrb),
    .wLast    (wLast),
    .arId     (arId),
    .arAddr   (arAddr),
    .arLen    (arLen),
    .arSize   (arSize),
    .arBurst  (arBurst),
    .bufValid (bufValid),
    .beatLast (beatLast),
    .bId      (bId),
    .bResp    (bResp),
    .rId      (rId),
    .rData    (rData),
    .rResp    (rResp),
    .rLast    (rLast)
  );

endmodule

// File: rtl/bms_checker.sv
module bms_checker #(
  parameter int ID_W   = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              awReady,
  input logic              wValid,
  input logic              wReady,
  input logic              wLast,
  input logic              bValid,
  input logic              bReady,
  input logic [1:0]        bResp,
  input logic [ID_W-1:0]   bId,
  input logic              arValid,
  input logic              arReady,
  input logic              rValid,
  input logic              rReady,
  input logic              rLast,
  input logic [1:0]        rResp,
  input logic [DATA_W-1:0] rData
);

  logic [3:0] lastPending;  // last beats accepted but not yet answered
  logic       rdOpen;       // a read address has been accepted and not finished

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastPending <= '0;
      rdOpen      <= 1'b0;
    end else begin
      lastPending <= lastPending + 4'(wValid && wReady && wLast) - 4'(bValid && bReady);
      if (arValid && arReady) rdOpen <= 1'b1;
      else if (rValid && rReady && rLast) rdOpen <= 1'b0;
    end
  end

  assert_aw_idle_ready_R1: assert property (@(posedge clk) disable iff (!rstN)
    (bValid && bReady) |=> awReady);

  assert_ar_idle_ready_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && rReady && rLast) |=> arReady);

  assert_one_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    bValid |-> !awReady);

  assert_resp_after_last_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bValid) |-> (lastPending != 4'd0));

  assert_b_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (bValid && !bReady) |=> (bValid && $stable(bResp) && $stable(bId)));

  assert_r_after_addr_R9: assert property (@(posedge clk) disable iff (!rstN)
    rValid |-> rdOpen);

  assert_r_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && !rReady) |=> (rValid && $stable(rData) && $stable(rLast) && $stable(rResp)));

  assert_resp_codes_R10: assert property (@(posedge clk) disable iff (!rstN)
    (bValid |-> (bResp == 2'b00 || bResp == 2'b10)) and
    (rValid |-> (rResp == 2'b00 || rResp == 2'b10)));

endmodule

bind burst_mem_slave bms_checker #(.ID_W(ID_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .awReady (awReady),
  .wValid  (wValid),
  .wReady  (wReady),
  .wLast   (wLast),
  .bValid  (bValid),
  .bReady  (bReady),
  .bResp   (bResp),
  .bId     (bId),
  .arValid (arValid),
  .arReady (arReady),
  .rValid  (rValid),
  .rReady  (rReady),
  .rLast   (rLast),
  .rResp   (rResp),
  .rData   (rData)
);

// File: tb/sim_burst_mem_slave.sv
`timescale 1ns/1ps
module sim_burst_mem_slave;

  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 32;
  localparam int ID_W      = 4;
  localparam int MEM_WORDS = 64;
  localparam int BYTES     = DATA_W / 8;
  localparam int MEM_BYTES = MEM_WORDS * BYTES;
  localparam int MAX_SZ    = $clog2(BYTES);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [ID_W-1:0]   awId = '0;
  logic [ADDR_W-1:0] awAddr = '0;
  logic [7:0]        awLen = '0;
  logic [2:0]        awSize = '0;
  logic [1:0]        awBurst = '0;
  logic              awValid = 1'b0;
  logic              awReady;
  logic [DATA_W-1:0] wData = '0;
  logic [BYTES-1:0]  wStrb = '0;
  logic              wLast = 1'b0;
  logic              wValid = 1'b0;
  logic              wReady;
  logic [ID_W-1:0]   bId;
  logic [1:0]        bResp;
  logic              bValid;
  logic              bReady = 1'b0;
  logic [ID_W-1:0]   arId = '0;
  logic [ADDR_W-1:0] arAddr = '0;
  logic [7:0]        arLen = '0;
  logic [2:0]        arSize = '0;
  logic [1:0]        arBurst = '0;
  logic              arValid = 1'b0;
  logic              arReady;
  logic [ID_W-1:0]   rId;
  logic [DATA_W-1:0] rData;
  logic [1:0]        rResp;
  logic              rLast;
  logic              rValid;
  logic              rReady = 1'b0;

  burst_mem_slave #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .MEM_WORDS(MEM_WORDS)
  ) u0 (
    .clk(clk), .rstN(rstN),
    .awId(awId), .awAddr(awAddr), .awLen(awLen), .awSize(awSize), .awBurst(awBurst),
    .awValid(awValid), .awReady(awReady),
    .wData(wData), .wStrb(wStrb), .wLast(wLast), .wValid(wValid), .wReady(wReady),
    .bId(bId), .bResp(bResp), .bValid(bValid), .bReady(bReady),
    .arId(arId), .arAddr(arAddr), .arLen(arLen), .arSize(arSize), .arBurst(arBurst),
    .arValid(arValid), .arReady(arReady),
    .rId(rId), .rData(rData), .rResp(rResp), .rLast(rLast), .rValid(rValid), .rReady(rReady)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [7:0]        model     [MEM_BYTES];
  logic [DATA_W-1:0] beatData  [256];
  logic [BYTES-1:0]  beatStrb  [256];

  task automatic checkEq(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int beatAddrOf(int start, int size, int len, int kind, int i);
    int nb;
    int total;
    int base;
    nb = 1 << size;
    if (kind == 0) return start;
    if (kind == 1) return (i == 0) ? start : (start / nb) * nb + i * nb;
    total = nb * (len + 1);
    base  = (start / total) * total;
    return base + ((start - base + i * nb) % total);
  endfunction

  function automatic bit descOk(int size, int len, int kind);
    if (size > MAX_SZ) return 1'b0;
    if (kind == 3) return 1'b0;
    if (kind != 1 && len > 15) return 1'b0;
    if (kind == 2 && !(len == 1 || len == 3 || len == 7 || len == 15)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [DATA_W-1:0] modelWord(int a);
    logic [DATA_W-1:0] w;
    for (int b = 0; b < BYTES; b++) w[8*b +: 8] = model[(a / BYTES) * BYTES + b];
    return w;
  endfunction

  task automatic sendAw(input int id, input int addr, input int len, input int size, input int kind);
    @(negedge clk);
    awId = ID_W'(id); awAddr = ADDR_W'(addr); awLen = 8'(len);
    awSize = 3'(size); awBurst = 2'(kind); awValid = 1'b1;
    #1;
    while (!awReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    awValid = 1'b0;
  endtask

  task automatic sendW(input int i, input int len);
    @(negedge clk);
    wData = beatData[i]; wStrb = beatStrb[i]; wLast = (i == len); wValid = 1'b1;
    #1;
    while (!wReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    wValid = 1'b0;
  endtask

  task automatic sendBoth(input int id, input int addr, input int len, input int size, input int kind);
    @(negedge clk);
    awId = ID_W'(id); awAddr = ADDR_W'(addr); awLen = 8'(len);
    awSize = 3'(size); awBurst = 2'(kind); awValid = 1'b1;
    wData = beatData[0]; wStrb = beatStrb[0]; wLast = (len == 0); wValid = 1'b1;
    #1;
    while (!(awReady && wReady)) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    awValid = 1'b0; wValid = 1'b0;
  endtask

  // order: 0 address first, 1 same cycle, 2 data first
  task automatic doWrite(input int id, input int addr, input int len, input int size,
                         input int kind, input int order, input int hold, input string req);
    bit expErr;
    int a;
    int nb;
    int lo;
    int first;
    logic [1:0] seenResp;
    expErr = !descOk(size, len, kind);
    nb = 1 << size;
    for (int i = 0; i <= len; i++) begin
      a = beatAddrOf(addr, size, len, kind, i);
      if (expErr || a >= MEM_BYTES) expErr = 1'b1;
      if (descOk(size, len, kind) && a < MEM_BYTES) begin
        lo = (a % BYTES) / nb * nb;
        for (int b = 0; b < BYTES; b++)
          if (b >= lo && b < lo + nb && beatStrb[i][b])
            model[(a / BYTES) * BYTES + b] = beatData[i][8*b +: 8];
      end
    end
    if (order == 2) begin sendW(0, len); sendAw(id, addr, len, size, kind); first = 1; end
    else if (order == 1) begin sendBoth(id, addr, len, size, kind); first = 1; end
    else begin sendAw(id, addr, len, size, kind); first = 0; end
    for (int i = first; i <= len; i++) sendW(i, len);
    @(negedge clk);
    while (!bValid) @(negedge clk);
    seenResp = bResp;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      checkEq("R8", "bValid held", 64'(bValid), 64'd1);
      checkEq("R8", "bResp held", 64'(bResp), 64'(seenResp));
    end
    checkEq(req, "bResp", 64'(bResp), expErr ? 64'd2 : 64'd0);
    checkEq("R8", "bId", 64'(bId), 64'(id[ID_W-1:0]));
    bReady = 1'b1;
    @(posedge clk); #1;
    bReady = 1'b0;
    @(negedge clk);
    checkEq("R8", "single response", 64'(bValid), 64'd0);
    checkEq("R1", "awReady back", 64'(awReady), 64'd1);
  endtask

  task automatic doRead(input int id, input int addr, input int len, input int size,
                        input int kind, input bit stall, input string req);
    int a;
    bit expErr;
    logic [DATA_W-1:0] held;
    @(negedge clk);
    arId = ID_W'(id); arAddr = ADDR_W'(addr); arLen = 8'(len);
    arSize = 3'(size); arBurst = 2'(kind); arValid = 1'b1;
    #1;
    while (!arReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    arValid = 1'b0;
    for (int i = 0; i <= len; i++) begin
      @(negedge clk);
      while (!rValid) @(negedge clk);
      if (stall && (i % 2 == 0)) begin
        held = rData;
        @(negedge clk);
        checkEq("R9", "rValid held", 64'(rValid), 64'd1);
        checkEq("R9", "rData held", 64'(rData), 64'(held));
      end
      a = beatAddrOf(addr, size, len, kind, i);
      expErr = !descOk(size, len, kind) || (a >= MEM_BYTES);
      checkEq(req, "rResp", 64'(rResp), expErr ? 64'd2 : 64'd0);
      checkEq("R9", "rLast", 64'(rLast), 64'(i == len));
      checkEq("R9", "rId", 64'(rId), 64'(id[ID_W-1:0]));
      if (!expErr) checkEq(req, "rData", 64'(rData), 64'(modelWord(a)));
      rReady = 1'b1;
      @(posedge clk); #1;
      rReady = 1'b0;
    end
    @(negedge clk);
    checkEq("R9", "no extra beat", 64'(rValid), 64'd0);
    checkEq("R1", "arReady back", 64'(arReady), 64'd1);
  endtask

  task automatic fillBeats(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      beatData[i] = DATA_W'(32'h9E3779B1 * (i + 1) + seed);
      beatStrb[i] = '1;
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    checkEq("R1", "awReady after reset", 64'(awReady), 64'd1);
    checkEq("R1", "arReady after reset", 64'(arReady), 64'd1);
    checkEq("R8", "bValid after reset", 64'(bValid), 64'd0);
    checkEq("R9", "rValid after reset", 64'(rValid), 64'd0);
  endtask

  task automatic testLongIncr();  // R2 R5: 256 byte beats fill the memory
    for (int i = 0; i < 256; i++) begin
      beatData[i] = {BYTES{8'(i * 7 + 3)}};
      beatStrb[i] = '1;
    end
    doWrite(1, 0, 255, 0, 1, 0, 0, "R2");
    doRead(2, 0, 63, 2, 1, 1'b0, "R2");
  endtask

  task automatic testWordIncr();  // R2 R8 R9: word burst, held response, stalled read
    fillBeats(4, 11);
    doWrite(3, 32'h20, 3, 2, 1, 0, 3, "R2");
    doRead(4, 32'h20, 3, 2, 1, 1'b1, "R9");
  endtask

  task automatic testDataOrder();  // R7: data before and with the address
    fillBeats(4, 23);
    doWrite(5, 32'h50, 3, 2, 1, 2, 0, "R7");
    doRead(5, 32'h50, 3, 2, 1, 1'b0, "R7");
    fillBeats(2, 37);
    doWrite(6, 32'h60, 1, 2, 1, 1, 0, "R7");
    doRead(6, 32'h60, 1, 2, 1, 1'b0, "R7");
    fillBeats(1, 41);
    doWrite(7, 32'h68, 0, 2, 1, 2, 0, "R7");
    doRead(7, 32'h68, 0, 2, 1, 1'b0, "R7");
  endtask

  task automatic testFixedStrobe();  // R3 R6
    fillBeats(4, 53);
    beatStrb[0] = 4'b0001; beatStrb[1] = 4'b0010; beatStrb[2] = 4'b0100; beatStrb[3] = 4'b1000;
    doWrite(8, 32'h44, 3, 2, 0, 0, 0, "R3");
    doRead(8, 32'h44, 3, 2, 0, 1'b0, "R3");
    fillBeats(2, 67);
    beatStrb[0] = 4'b0101; beatStrb[1] = 4'b1010;
    doWrite(9, 32'hC0, 1, 2, 1, 0, 0, "R6");
    doRead(9, 32'hC0, 1, 2, 1, 1'b0, "R6");
  endtask

  task automatic testWrap();  // R4
    fillBeats(4, 79);
    doWrite(10, 32'h38, 3, 2, 2, 0, 0, "R4");
    doRead(10, 32'h30, 3, 2, 1, 1'b0, "R4");
    doRead(11, 32'h34, 3, 2, 2, 1'b0, "R4");
    fillBeats(8, 83);
    doWrite(12, 32'hA6, 7, 1, 2, 0, 0, "R4");
    doRead(12, 32'hA0, 3, 2, 1, 1'b0, "R4");
    fillBeats(2, 89);
    doWrite(13, 32'h71, 1, 0, 2, 0, 0, "R4");
    doRead(13, 32'h70, 0, 2, 1, 1'b0, "R4");
  endtask

  task automatic testNarrow();  // R5: half-word beats with all strobes set
    fillBeats(4, 97);
    doWrite(14, 32'h92, 3, 1, 1, 0, 0, "R5");
    doRead(14, 32'h90, 2, 2, 1, 1'b0, "R5");
  endtask

  task automatic testErrors();  // R10
    fillBeats(4, 101);
    doWrite(1, 32'hF8, 3, 2, 1, 0, 0, "R10");
    doRead(1, 32'hF8, 3, 2, 1, 1'b0, "R10");
    fillBeats(2, 103);
    doWrite(2, 32'h300, 1, 2, 1, 0, 0, "R10");
    doRead(2, 32'h300, 1, 2, 1, 1'b0, "R10");
    fillBeats(2, 107);
    doWrite(3, 32'h10, 1, 3, 1, 0, 0, "R10");
    doRead(3, 32'h10, 1, 2, 1, 1'b0, "R10");
    fillBeats(3, 109);
    doWrite(4, 32'hE0, 2, 2, 2, 0, 0, "R10");
    doRead(4, 32'hE0, 2, 2, 1, 1'b0, "R10");
    doRead(5, 32'h00, 1, 2, 3, 1'b0, "R10");
  endtask

  initial begin
    for (int i = 0; i < MEM_BYTES; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testLongIncr();
    testWordIncr();
    testDataOrder();
    testFixedStrobe();
    testWrap();
    testNarrow();
    testErrors();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule